// File: doc/BRIEF.md
# Programmable Sum-of-Products Term Array

This block is the logic core of a small programmable logic device. Twelve dedicated input signals and ten feedback signals each drive two array lines, one true and one inverted. That gives 44 lines. Each of the 132 product terms ANDs together the lines whose connection bit is set in a stored connection memory.

Most terms are grouped into ten OR sums, and the groups have unequal sizes. The remaining terms serve as ten per-output enable terms, one global preset term and one global clear term. The macrocells that use these results sit outside this block.

The connection memory is loaded through a configuration port. The port can replace a whole term row at once or change a single connection bit. A separate read port returns any stored row, which lets the configuration be verified. All results are registered. On a clock edge that carries a configuration write, the results hold their value. A new configuration shows up on the first edge without a write.

Top module: `pt_array`

## Requirements
- R1: Signal s drives two array lines: line 2s carries its true value and line 2s+1 its inverse. Signals 0 to 11 are `ded_in[0..11]` and signals 12 to 21 are `fb_in[0..9]`. A term is the AND of every line whose connection bit is 1.
- R2: A term whose 44 connection bits are all 0 evaluates to 1 for every input pattern.
- R3: A term connected to both lines of any one signal evaluates to 0 for every input pattern. This holds for the all-connected state as well.
- R4: Terms 0 to 119 are the sum terms. Output o owns 8+2*min(o,9-o) consecutive terms, placed directly after those of outputs 0..o-1: output 0 owns terms 0-7, output 4 starts at term 44, and output 9 owns terms 112-119. `sum_out[o]` is the OR of the terms output o owns.
- R5: Term 120+o drives `oe_out[o]`, term 130 drives `preset_out` and term 131 drives `clear_out`.
- R6: After reset every connection bit is 1, all outputs are 0, and every row reads back as all ones.
- R7: `cfg_row_we` with `cfg_term` below 132 replaces that term's row with `cfg_row`. `rd_row` shows the row selected by `rd_term` in the same cycle, with no wait for a clock edge.
- R8: `cfg_bit_we` sets bit `cfg_line` of row `cfg_term` to `cfg_bit`. When both write enables are high in the same cycle, the row write takes effect and the bit write is dropped.
- R9: On a clock edge where either write enable is high, all four outputs keep their previous value. The first edge without a write evaluates the terms using the new configuration.
- R10: A write whose term index is 132 or higher, or a bit write whose line index is 44 or higher, changes no stored bit and no output. A read of a term index of 132 or higher returns 0.
- R11: The outputs are registered. They reflect the inputs and configuration present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals |
| cfg_row_we | input | 1 | Whole-row write enable |
| cfg_bit_we | input | 1 | Single-bit write enable |
| cfg_term | input | 8 | Term index for writes |
| cfg_line | input | 6 | Line index for bit writes |
| cfg_row | input | 44 | Row data for row writes |
| cfg_bit | input | 1 | Bit value for bit writes |
| rd_term | input | 8 | Term index for readback |
| rd_row | output | 44 | Stored connection row of `rd_term` |
| sum_out | output | 10 | Registered OR sums |
| oe_out | output | 10 | Registered per-output enable terms |
| preset_out | output | 1 | Registered global preset term |
| clear_out | output | 1 | Registered global clear term |

## Verification
Four rules are checked on every cycle. Outputs stay frozen across any write edge. A valid row write or bit write appears on the readback port one cycle later. Out-of-range writes leave the readback untouched.

The term arithmetic can only be shown by the bench's scenarios. Those scenarios cover the fixed values of fully open and contradictory terms, the unequal grouping of terms into outputs, and the line ordering. They also cover the one-cycle latency and the row-over-bit priority. For these, the bench runs a model of the connection memory against chosen and random input patterns.

// File: rtl/pt_array.sv
module pt_array #(
  parameter int N_DED     = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int STEP      = 2,
  localparam int N_SIG    = N_DED + N_OUT,
  localparam int N_LINES  = 2 * N_SIG,
  localparam int N_SUM_T  = N_OUT * MIN_TERMS + STEP * (((N_OUT - 1) * (N_OUT - 1)) / 4),
  localparam int N_TERMS  = N_SUM_T + N_OUT + 2,
  localparam int TW       = $clog2(N_TERMS + 1),
  localparam int LW       = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_DED-1:0]   ded_in,
  input  logic [N_OUT-1:0]   fb_in,
  input  logic               cfg_row_we,
  input  logic               cfg_bit_we,
  input  logic [TW-1:0]      cfg_term,
  input  logic [LW-1:0]      cfg_line,
  input  logic [N_LINES-1:0] cfg_row,
  input  logic               cfg_bit,
  input  logic [TW-1:0]      rd_term,
  output logic [N_LINES-1:0] rd_row,
  output logic [N_OUT-1:0]   sum_out,
  output logic [N_OUT-1:0]   oe_out,
  output logic               preset_out,
  output logic               clear_out
);

  localparam int T_OE  = N_SUM_T;
  localparam int T_PRE = N_SUM_T + N_OUT;
  localparam int T_CLR = T_PRE + 1;

  function automatic int terms_for(int o);
    int m;
    m = (o < N_OUT - 1 - o) ? o : N_OUT - 1 - o;
    return MIN_TERMS + STEP * m;
  endfunction

  function automatic int base_of(int o);
    int s;
    s = 0;
    for (int k = 0; k < o; k++) s += terms_for(k);
    return s;
  endfunction

  logic [N_LINES-1:0] conn [N_TERMS];
  logic [N_SIG-1:0]   sig;
  logic [N_LINES-1:0] lines;
  logic [N_TERMS-1:0] term_v;
  logic [N_OUT-1:0]   sum_d;
  logic               term_ok, line_ok, any_we;

  assign sig     = {fb_in, ded_in};
  assign term_ok = cfg_term < TW'(N_TERMS);
  assign line_ok = cfg_line < LW'(N_LINES);
  assign any_we  = cfg_row_we | cfg_bit_we;
  assign rd_row  = (rd_term < TW'(N_TERMS)) ? conn[rd_term] : '0;

  for (genvar s = 0; s < N_SIG; s++) begin : g_line
    assign lines[2*s]   = sig[s];
    assign lines[2*s+1] = ~sig[s];
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign term_v[t] = &(~conn[t] | lines);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    localparam int OFF = base_of(o);
    localparam int CNT = terms_for(o);
    assign sum_d[o] = |term_v[OFF +: CNT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < N_TERMS; t++) conn[t] <= '1;
    end else if (cfg_row_we) begin
      if (term_ok) conn[cfg_term] <= cfg_row;
    end else if (cfg_bit_we) begin
      if (term_ok && line_ok) conn[cfg_term][cfg_line] <= cfg_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out    <= '0;
      oe_out     <= '0;
      preset_out <= 1'b0;
      clear_out  <= 1'b0;
    end else if (!any_we) begin
      sum_out    <= sum_d;
      oe_out     <= term_v[T_OE +: N_OUT];
      preset_out <= term_v[T_PRE];
      clear_out  <= term_v[T_CLR];
    end
  end

endmodule

// File: rtl/pt_array_chk.sv
module pt_array_chk #(
  parameter int NT    = 132,
  parameter int NL    = 44,
  parameter int N_OUT = 10,
  parameter int TW    = 8,
  parameter int LW    = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_row_we,
  input logic            cfg_bit_we,
  input logic [TW-1:0]   cfg_term,
  input logic [LW-1:0]   cfg_line,
  input logic [NL-1:0]   cfg_row,
  input logic            cfg_bit,
  input logic [TW-1:0]   rd_term,
  input logic [NL-1:0]   rd_row,
  input logic [N_OUT-1:0] sum_out,
  input logic [N_OUT-1:0] oe_out,
  input logic            preset_out,
  input logic            clear_out
);

  assert_write_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_row_we || cfg_bit_we) |=>
      ($stable(sum_out) && $stable(oe_out) && $stable(preset_out) && $stable(clear_out)));

  assert_row_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_row_we && cfg_term < TW'(NT)) |=>
      (rd_term != $past(cfg_term) || rd_row == $past(cfg_row)));

  assert_bit_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bit_we && !cfg_row_we && cfg_term < TW'(NT) && cfg_line < LW'(NL)) |=>
      (rd_term != $past(cfg_term) || rd_row[$past(cfg_line)] == $past(cfg_bit)));

  assert_oob_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_row_we && cfg_term >= TW'(NT)) |=>
      (rd_term != $past(rd_term) || $stable(rd_row)));

endmodule

bind pt_array pt_array_chk #(
  .NT(N_TERMS), .NL(N_LINES), .N_OUT(N_OUT), .TW(TW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_row_we(cfg_row_we), .cfg_bit_we(cfg_bit_we),
  .cfg_term(cfg_term), .cfg_line(cfg_line), .cfg_row(cfg_row), .cfg_bit(cfg_bit),
  .rd_term(rd_term), .rd_row(rd_row), .sum_out(sum_out), .oe_out(oe_out),
  .preset_out(preset_out), .clear_out(clear_out)
);

// File: tb/pt_array_bench.sv
module pt_array_bench;
  localparam int ND = 12, NO = 10, NL = 44, NT = 132;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [ND-1:0] ded_in = '0;
  logic [NO-1:0] fb_in = '0;
  logic          cfg_row_we = 1'b0, cfg_bit_we = 1'b0, cfg_bit = 1'b0;
  logic [7:0]    cfg_term = '0, rd_term = '0;
  logic [5:0]    cfg_line = '0;
  logic [NL-1:0] cfg_row = '0, rd_row;
  logic [NO-1:0] sum_out, oe_out;
  logic          preset_out, clear_out;

  pt_array u_pt_array (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
    .cfg_row_we(cfg_row_we), .cfg_bit_we(cfg_bit_we), .cfg_term(cfg_term),
    .cfg_line(cfg_line), .cfg_row(cfg_row), .cfg_bit(cfg_bit),
    .rd_term(rd_term), .rd_row(rd_row), .sum_out(sum_out), .oe_out(oe_out),
    .preset_out(preset_out), .clear_out(clear_out)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [NL-1:0] mdl [NT];
  logic [21:0]   exp_q [$];
  string         tag_q [$];
  logic [21:0]   last_exp = '0;

  function automatic logic [21:0] eval_model(logic [ND-1:0] d, logic [NO-1:0] f);
    logic [NL-1:0] ln;
    logic [NT-1:0] tv;
    logic [21:0] r;
    int base;
    for (int s = 0; s < ND + NO; s++) begin
      logic v;
      v = (s < ND) ? d[s] : f[s-ND];
      ln[2*s] = v;
      ln[2*s+1] = ~v;
    end
    for (int t = 0; t < NT; t++) tv[t] = &(~mdl[t] | ln);
    r = '0;
    base = 0;
    for (int o = 0; o < NO; o++) begin
      int cnt;
      cnt = 8 + 2 * ((o < 9 - o) ? o : 9 - o);
      for (int k = 0; k < cnt; k++) r[o] = r[o] | tv[base+k];
      base += cnt;
    end
    for (int o = 0; o < NO; o++) r[10+o] = tv[120+o];
    r[20] = tv[130];
    r[21] = tv[131];
    return r;
  endfunction

  function automatic logic [21:0] outs();
    return {clear_out, preset_out, oe_out, sum_out};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic push(logic [21:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [21:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(tg, 64'(outs()), 64'(e));
    end
  end

  task automatic apply(logic [ND-1:0] d, logic [NO-1:0] f, string tag);
    @(negedge clk);
    cfg_row_we = 1'b0; cfg_bit_we = 1'b0;
    ded_in = d; fb_in = f;
    @(posedge clk);
    last_exp = eval_model(ded_in, fb_in);
    push(last_exp, tag);
  endtask

  task automatic wr_row(int t, logic [NL-1:0] v, string tag);
    @(negedge clk);
    cfg_row_we = 1'b1; cfg_bit_we = 1'b0;
    cfg_term = t[7:0]; cfg_row = v;
    @(posedge clk);
    push(last_exp, tag);
    if (t < NT) mdl[t] = v;
  endtask

  task automatic wr_bit(int t, int l, logic b, string tag);
    @(negedge clk);
    cfg_row_we = 1'b0; cfg_bit_we = 1'b1;
    cfg_term = t[7:0]; cfg_line = l[5:0]; cfg_bit = b;
    @(posedge clk);
    push(last_exp, tag);
    if (t < NT && l < NL) mdl[t][l] = b;
  endtask

  task automatic wr_both(int t, logic [NL-1:0] v, int l, logic b, string tag);
    @(negedge clk);
    cfg_row_we = 1'b1; cfg_bit_we = 1'b1;
    cfg_term = t[7:0]; cfg_row = v; cfg_line = l[5:0]; cfg_bit = b;
    @(posedge clk);
    push(last_exp, tag);
    if (t < NT) mdl[t] = v;
  endtask

  task automatic rb(int t, string tag);
    @(negedge clk);
    cfg_row_we = 1'b0; cfg_bit_we = 1'b0;
    rd_term = t[7:0];
    #1;
    check(tag, 64'(rd_row), 64'((t < NT) ? mdl[t] : '0));
    @(posedge clk);
    last_exp = eval_model(ded_in, fb_in);
    push(last_exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) mdl[t] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state
    check("R6 outputs", 64'(outs()), 64'(0));
    rb(0, "R6 readback");
    rb(131, "R6 readback");

    apply('0, '0, "R3 all intact");
    apply('1, '1, "R3 all intact");

    wr_row(130, '0, "R9 hold on write");
    apply(12'h5a5, 10'h0f3, "R2 open preset R5");
    apply(12'h000, 10'h000, "R2 open preset R5");

    wr_row(0, 44'h1, "R9 hold on write");
    apply(12'h001, '0, "R1 ded0 true");
    apply(12'h000, '0, "R1 ded0 false R11");
    apply(12'h001, '0, "R11 latency");

    wr_row(44, 44'(1) << 25, "R9 hold");
    apply('0, 10'h000, "R4 output4 first term");
    apply('0, 10'h001, "R4 output4 first term");

    wr_row(119, (44'(1) << 22) | (44'(1) << 42), "R9 hold");
    apply(12'h800, 10'h200, "R4 output9 last term");
    apply(12'h800, 10'h000, "R4 output9 last term");
    apply(12'h000, 10'h200, "R4 output9 last term");

    wr_row(1, 44'hc, "R9 hold");
    apply(12'h000, '0, "R3 contradictory");
    apply(12'h002, '0, "R3 contradictory");

    wr_row(125, '0, "R9 hold");
    wr_bit(125, 5, 1'b1, "R9 hold");
    apply(12'h000, '0, "R8 bit write oe5 R5");
    apply(12'h004, '0, "R8 bit write oe5 R5");
    rb(125, "R8 readback");

    wr_both(131, '0, 3, 1'b1, "R9 hold");
    rb(131, "R8 row priority R7");
    apply(12'h0ff, 10'h155, "R8 row priority clear R5");

    wr_row(200, '0, "R10 oob row");
    wr_bit(0, 50, 1'b0, "R10 oob line");
    apply(12'h001, '0, "R10 no effect");
    rb(0, "R10 readback unchanged");
    rb(140, "R10 oob read zero");

    for (int i = 0; i < 40; i++) begin
      int t;
      logic [NL-1:0] v;
      t = int'($urandom_range(0, NT - 1));
      v = '0;
      if ($urandom_range(0, 4) != 0)
        for (int b = 0; b < NL; b++) v[b] = ($urandom_range(0, 15) == 0);
      wr_row(t, v, "R9 hold random");
      rb(t, "R7 random readback");
      apply(ND'($urandom), NO'($urandom), "R1 random");
      apply(ND'($urandom), NO'($urandom), "R11 random");
    end

    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule